// File: doc/BRIEF.md
# Write Data Parity Checker

This block watches the write data entering a byte-laned synchronous memory and flags any lane whose parity is wrong. Each lane is nine bits wide: eight data bits and one parity bit on top. A static strap selects whether a correct lane holds an even or an odd count of ones across all nine bits. A second static strap chooses the reporting latency, so that the error report stays aligned with the memory's flow-through or pipelined output timing.

Only lanes that take part in the current write are checked. A lane takes part when its own byte enable is set, or when the all-lanes write control is set. Cycles without a write are never checked, and read data plays no part at all. The error output is active low and is only ever pulled low, so the outputs of several checkers can share one pulled-up net. Every write cycle gets its own one-cycle report slot.

Top module: `write_parity_checker`

## Requirements
- R1: With `par_even` = 1, an enabled lane whose nine bits (data plus parity bit, the parity bit at lane bit 8) hold an odd number of ones is an error; an even count is clean.
- R2: With `par_even` = 0, an enabled lane whose nine bits hold an even number of ones is an error; an odd count is clean.
- R3: With `pipe_mode` = 0, a write sampled at clock edge k drives `perr_n` low from edge k until edge k+1, and only for that one cycle.
- R4: With `pipe_mode` = 1, the same report appears one edge later, from edge k+1 until edge k+2, and `perr_n` stays high between edges k and k+1.
- R5: A lane whose bit in `lane_en` is 0 is not checked while `all_lanes` is 0. A parity fault on that lane leaves `perr_n` high.
- R6: With `all_lanes` = 1, every lane is checked whatever the value of `lane_en`.
- R7: A cycle with `wr_valid` = 0 is never checked. Bad parity on that cycle leaves `perr_n` high.
- R8: `perr_n` reports the OR of all lane errors. A fault in any single lane, including the highest-numbered lane, is reported, and so are faults in several lanes at once.
- R9: While `rst_n` is low, `perr_n` is high. An error captured before reset is never reported after reset is released.
- R10: Back-to-back writes are reported independently. Each write's report occupies its own cycle slot, and a clean write between two bad ones gives a high `perr_n` in its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | The current cycle is a write cycle |
| wr_data | input | LANES*(DATA_W+1) | Write data. Lane i sits at bits [i*(DATA_W+1) +: DATA_W+1]; its top bit is the parity bit |
| lane_en | input | LANES | Per-lane write enable, active high |
| all_lanes | input | 1 | Write all lanes, overriding `lane_en` |
| par_even | input | 1 | Strap: 1 expects even parity, 0 expects odd parity |
| pipe_mode | input | 1 | Strap: 1 selects pipeline latency, 0 selects flow-through latency |
| perr_n | output | 1 | Parity error report, active low; high means released |

## Verification
The checker properties assume that `wr_data`, `lane_en`, `all_lanes` and the straps are stable at each rising edge. They also assume that the latency strap is treated as a static configuration: its properties compare the output against inputs from one or two edges back, whichever mode is currently selected. The bench drives every input on the falling edge and samples `perr_n` on the following falling edge. It changes `pipe_mode` and `par_even` only between scenarios, after idle cycles have flushed the report stages, so that every edge the properties inspect sees settled, legal values.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic {
      RPT_FLOW = 1'b0,
      RPT_PIPE = 1'b1
   } rpt_mode_e;

   // ones_odd: reduction XOR of all nine lane bits
   // want_even: expected parity sense
   function automatic logic parity_fail(input logic ones_odd, input logic want_even);
      return ~(ones_odd ^ want_even);
   endfunction

endpackage

// File: rtl/wpc_lane.sv
module wpc_lane #(
   parameter int DATA_W = 8,
   localparam int LANE_W = DATA_W + 1
) (
   input  logic [LANE_W-1:0] lane_bits,
   input  logic              active,
   input  logic              want_even,
   output logic              fault
);
   import wpc_pkg::*;

   logic ones_odd;

   always_comb begin
      ones_odd = ^lane_bits;
      fault    = active & parity_fail(ones_odd, want_even);
   end

endmodule

// File: rtl/wpc_report.sv
module wpc_report #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic pipe_mode,
   output logic perr_n
);
   import wpc_pkg::*;

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= hit;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   rpt_mode_e mode;

   always_comb begin
      mode = rpt_mode_e'(pipe_mode);
      if (mode == RPT_PIPE) perr_n = ~stage_q[STAGES-1];
      else                  perr_n = ~stage_q[0];
   end

endmodule

// File: rtl/write_parity_checker.sv
module write_parity_checker #(
   parameter int LANES  = 4,
   parameter int DATA_W = 8,
   localparam int LANE_W = DATA_W + 1,
   localparam int BUS_W  = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [BUS_W-1:0] wr_data,
   input  logic [LANES-1:0] lane_en,
   input  logic             all_lanes,
   input  logic             par_even,
   input  logic             pipe_mode,
   output logic             perr_n
);

   if (LANES < 1) begin : g_bad_lanes
      $error("write_parity_checker: LANES must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("write_parity_checker: DATA_W must be at least 1");
   end

   logic [LANES-1:0] lane_fault;
   logic             any_fault;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      wpc_lane #(.DATA_W(DATA_W)) u_lane (
         .lane_bits (wr_data[i*LANE_W +: LANE_W]),
         .active    (lane_en[i] | all_lanes),
         .want_even (par_even),
         .fault     (lane_fault[i])
      );
   end

   assign any_fault = wr_valid & (|lane_fault);

   wpc_report #(.STAGES(2)) u_report (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (any_fault),
      .pipe_mode (pipe_mode),
      .perr_n    (perr_n)
   );

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
   parameter int LANES  = 4,
   parameter int DATA_W = 8,
   localparam int LANE_W = DATA_W + 1,
   localparam int BUS_W  = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid,
   input logic [BUS_W-1:0] wr_data,
   input logic [LANES-1:0] lane_en,
   input logic             all_lanes,
   input logic             par_even,
   input logic             pipe_mode,
   input logic             perr_n
);

   logic [1:0] cyc;
   logic       exp_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cyc <= 2'd0;
      else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
   end

   always_comb begin
      exp_bad = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if ((lane_en[i] || all_lanes) &&
             ((^wr_data[i*LANE_W +: LANE_W]) == par_even))
            exp_bad = 1'b1;
      end
      exp_bad = exp_bad && wr_valid;
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> perr_n);                                            // R9

   AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && !pipe_mode) |-> (perr_n == !$past(exp_bad)));  // R3

   AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && pipe_mode) |-> (perr_n == !$past(exp_bad, 2))); // R4

   AST_NO_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && !pipe_mode && !$past(wr_valid)) |-> perr_n);   // R7

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && !pipe_mode && $past(lane_en) == '0 && !$past(all_lanes))
      |-> perr_n);                                                   // R5

endmodule

bind write_parity_checker wpc_checker #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .wr_data   (wr_data),
   .lane_en   (lane_en),
   .all_lanes (all_lanes),
   .par_even  (par_even),
   .pipe_mode (pipe_mode),
   .perr_n    (perr_n)
);

// File: tb/write_parity_checker_test.sv
module write_parity_checker_test;

   localparam int LANES  = 4;
   localparam int DATA_W = 8;
   localparam int LANE_W = DATA_W + 1;
   localparam int BUS_W  = LANES * LANE_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_valid = 1'b0;
   logic [BUS_W-1:0] wr_data = '0;
   logic [LANES-1:0] lane_en = '0;
   logic             all_lanes = 1'b0;
   logic             par_even = 1'b1;
   logic             pipe_mode = 1'b0;
   logic             perr_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   write_parity_checker #(.LANES(LANES), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .lane_en(lane_en), .all_lanes(all_lanes), .par_even(par_even),
      .pipe_mode(pipe_mode), .perr_n(perr_n)
   );

   // Build a bus: lane i holds seed+i*37, parity set for sense 'even',
   // lanes with a set bit in bad_mask get their parity bit flipped.
   function automatic logic [BUS_W-1:0] mk_bus(input logic [7:0] seed, input logic even,
                                               input logic [LANES-1:0] bad_mask);
      logic [BUS_W-1:0] w;
      w = '0;
      for (int i = 0; i < LANES; i++) begin
         logic [7:0] b;
         logic       p;
         b = seed + 8'(i * 37);
         p = even ? ^b : ~^b;
         w[i*LANE_W +: LANE_W] = {p ^ bad_mask[i], b};
      end
      return w;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: perr_n=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one cycle of inputs on the falling edge; return at the next falling edge.
   task automatic step(input logic v, input logic [BUS_W-1:0] d,
                       input logic [LANES-1:0] en, input logic all);
      wr_valid  = v;
      wr_data   = d;
      lane_en   = en;
      all_lanes = all;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0);
   endtask

   task automatic t_reset;
      check("R9 reset state", perr_n, 1'b1);
      pipe_mode = 1'b1;
      par_even  = 1'b1;
      idle(2);
      step(1'b1, mk_bus(8'h11, 1'b1, 4'b0001), 4'hF, 1'b0);
      rst_n = 1'b0;
      #1;
      check("R9 held in reset", perr_n, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      check("R9 no stale report", perr_n, 1'b1);
      idle(1);
      check("R9 no stale report later", perr_n, 1'b1);
      pipe_mode = 1'b0;
      idle(2);
   endtask

   task automatic t_even;
      par_even = 1'b1;
      step(1'b1, mk_bus(8'h5A, 1'b1, 4'b0000), 4'hF, 1'b0);
      check("R1 even clean", perr_n, 1'b1);
      step(1'b1, mk_bus(8'h5A, 1'b1, 4'b0001), 4'hF, 1'b0);
      check("R1 even fault", perr_n, 1'b0);
      step(1'b1, '0, 4'hF, 1'b0);
      check("R1 all-zero lanes clean", perr_n, 1'b1);
      idle(1);
   endtask

   task automatic t_odd;
      par_even = 1'b0;
      idle(2);
      step(1'b1, mk_bus(8'h3C, 1'b1, 4'b0000), 4'hF, 1'b0);
      check("R2 even data under odd sense", perr_n, 1'b0);
      step(1'b1, mk_bus(8'h3C, 1'b0, 4'b0000), 4'hF, 1'b0);
      check("R2 odd data clean", perr_n, 1'b1);
      step(1'b1, '0, 4'hF, 1'b0);
      check("R2 all-zero lanes fault", perr_n, 1'b0);
      par_even = 1'b1;
      idle(2);
   endtask

   task automatic t_flow;
      pipe_mode = 1'b0;
      step(1'b1, mk_bus(8'h77, 1'b1, 4'b0100), 4'hF, 1'b0);
      check("R3 flow report cycle", perr_n, 1'b0);
      idle(1);
      check("R3 flow released next cycle", perr_n, 1'b1);
   endtask

   task automatic t_pipe;
      pipe_mode = 1'b1;
      idle(2);
      step(1'b1, mk_bus(8'h77, 1'b1, 4'b0100), 4'hF, 1'b0);
      check("R4 pipe not yet", perr_n, 1'b1);
      idle(1);
      check("R4 pipe report cycle", perr_n, 1'b0);
      idle(1);
      check("R4 pipe released", perr_n, 1'b1);
      step(1'b0, mk_bus(8'h01, 1'b1, 4'b1111), 4'hF, 1'b0);
      idle(1);
      check("R7 pipe no write", perr_n, 1'b1);
      pipe_mode = 1'b0;
      idle(2);
   endtask

   task automatic t_mask;
      step(1'b1, mk_bus(8'h90, 1'b1, 4'b0100), 4'b1011, 1'b0);
      check("R5 disabled lane ignored", perr_n, 1'b1);
      step(1'b1, mk_bus(8'h90, 1'b1, 4'b0100), 4'b0100, 1'b0);
      check("R5 enabled lane checked", perr_n, 1'b0);
      step(1'b1, mk_bus(8'h90, 1'b1, 4'b1111), 4'b0000, 1'b0);
      check("R5 no lanes enabled", perr_n, 1'b1);
      idle(1);
   endtask

   task automatic t_all;
      step(1'b1, mk_bus(8'hC3, 1'b1, 4'b0010), 4'b0000, 1'b1);
      check("R6 all lanes overrides enables", perr_n, 1'b0);
      step(1'b1, mk_bus(8'hC3, 1'b1, 4'b0000), 4'b0000, 1'b1);
      check("R6 all lanes clean", perr_n, 1'b1);
   endtask

   task automatic t_novalid;
      step(1'b0, mk_bus(8'h42, 1'b1, 4'b1111), 4'hF, 1'b1);
      check("R7 no write no check", perr_n, 1'b1);
   endtask

   task automatic t_or;
      step(1'b1, mk_bus(8'hE1, 1'b1, 4'b1000), 4'hF, 1'b0);
      check("R8 top lane fault", perr_n, 1'b0);
      step(1'b1, mk_bus(8'hE1, 1'b1, 4'b1010), 4'hF, 1'b0);
      check("R8 several lane faults", perr_n, 1'b0);
      idle(1);
   endtask

   task automatic t_b2b;
      step(1'b1, mk_bus(8'h21, 1'b1, 4'b0001), 4'hF, 1'b0);
      check("R10 flow first bad", perr_n, 1'b0);
      step(1'b1, mk_bus(8'h22, 1'b1, 4'b0000), 4'hF, 1'b0);
      check("R10 flow clean between", perr_n, 1'b1);
      step(1'b1, mk_bus(8'h23, 1'b1, 4'b0010), 4'hF, 1'b0);
      check("R10 flow second bad", perr_n, 1'b0);
      pipe_mode = 1'b1;
      idle(2);
      step(1'b1, mk_bus(8'h21, 1'b1, 4'b0001), 4'hF, 1'b0);
      step(1'b1, mk_bus(8'h22, 1'b1, 4'b0000), 4'hF, 1'b0);
      check("R10 pipe first bad", perr_n, 1'b0);
      step(1'b1, mk_bus(8'h23, 1'b1, 4'b0010), 4'hF, 1'b0);
      check("R10 pipe clean between", perr_n, 1'b1);
      idle(1);
      check("R10 pipe second bad", perr_n, 1'b0);
      idle(1);
      check("R10 pipe released", perr_n, 1'b1);
      pipe_mode = 1'b0;
      idle(2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_even();
      t_odd();
      t_flow();
      t_pipe();
      t_mask();
      t_all();
      t_novalid();
      t_or();
      t_b2b();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run ended=0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule